// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command pins of a synchronous DRAM from reset until the device can take normal traffic. While the supply and clock settle, it keeps clock enable and the data mask high and places only no-operation commands on the bus. The quiet period is at least 200 microseconds, which the block converts to clock cycles from a clock-frequency parameter. After that period it issues a precharge of every bank, a group of auto-refresh commands and a mode-register load. Parameterized waits separate the commands, and no-operation commands fill every cycle between them.

A strap input sets the order of the refresh group and the mode load. The mode word comes either from a parameter or from an input port, and its reserved bits are forced to zero before they reach the address pins. `init_done` rises once the wait after the final command has expired. An asynchronous reset at any time sends the block back to the start of the quiet period. Refresh scheduling after initialization and read/write arbitration are handled elsewhere.

The controller is one enumerated state machine. Its states are:

- `ST_STABLE`: the quiet wait.
- `ST_PRECHG`: the precharge-all command.
- `ST_PRE_WAIT`: the wait after the precharge.
- `ST_REFRESH`: one auto-refresh command.
- `ST_REF_WAIT`: the wait after a refresh.
- `ST_MODESET`: the mode-register load.
- `ST_MODE_WAIT`: the wait after the mode load.
- `ST_READY`: initialization complete.

Its transitions are:

- stable to precharge, when the quiet count expires.
- precharge to pre-wait.
- pre-wait to refresh (when `mode_last`=1) or to modeset (when `mode_last`=0).
- refresh to ref-wait.
- ref-wait to refresh, while the group is incomplete.
- ref-wait to modeset (when `mode_last`=1) or to ready (when `mode_last`=0), once the group is complete.
- modeset to mode-wait.
- mode-wait to ready (when `mode_last`=1) or to refresh (when `mode_last`=0).
- any state to stable, on reset.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: `cke` and `dqm` are high in every cycle, during reset and after it.
- R2: For the first STABLE_CYC = CLK_MHZ*200 rising edges after reset release, the pins carry only NOP ({cs_n,ras_n,cas_n,we_n} = 0111) with `addr` zero. The precharge-all appears immediately after edge STABLE_CYC.
- R3: The precharge-all is encoded {cs_n,ras_n,cas_n,we_n} = 0010, with `addr` bit AP_BIT (default 10) high and every other address bit low.
- R4: The refresh group holds max(REF_COUNT,2) auto-refresh commands, each encoded 0001 with `addr` zero. A REF_COUNT below 2 gives two refreshes.
- R5: The mode load is encoded 0000. Its `addr` is the mode word ANDed with the inverse of RSVD_MASK (default 0xC00). The word is `mode_word` when USE_MODE_PORT=1 and the MODE_WORD parameter otherwise.
- R6: The precharge-all comes first. With `mode_last`=1 the order is the refreshes, then the mode load. With `mode_last`=0 the order is the mode load, then the refreshes.
- R7: Every command lasts one cycle and is followed by NOPs. The next command appears 1+D cycles after it, where D is T_RP after the precharge, T_RFC after a refresh and T_MRD after the mode load.
- R8: `init_done` rises 1+D cycles after the last command, where D is that command's wait. It then stays high, and only NOPs follow.
- R9: Asserting `rst_n` low at any point drives NOP and a low `init_done` at once. After release, the whole sequence repeats from the quiet wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_last | input | 1 | Strap: 1 puts the mode load after the refresh group, 0 puts it before |
| mode_word | input | ADDR_W | Mode word, used when USE_MODE_PORT=1 |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | 1 | Data mask to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins, carrying the precharge-all bit or the mode word |
| init_done | output | 1 | High once the sequence has completed |

## Verification
The checker assumes that `mode_last` and `mode_word` hold steady from reset release until `init_done` rises, because the order and the mode address are read live from them. The stimulus changes the strap and the word only while `rst_n` is low. Those values come from seeded random draws, mixed with directed all-ones and all-zero words. A reduced clock-frequency parameter keeps each quiet wait short. Resets are also applied in the middle of a sequence and after completion, to exercise the restart.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_STABLE,
        ST_PRECHG,
        ST_PRE_WAIT,
        ST_REFRESH,
        ST_REF_WAIT,
        ST_MODESET,
        ST_MODE_WAIT,
        ST_READY
    } init_state_t;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRECHG,
        CMD_REFRESH,
        CMD_MODESET
    } init_cmd_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_cmd_t;

    function automatic int clamp_min(input int v, input int lo);
        return (v < lo) ? lo : v;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
    parameter int         W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/init_ref_counter.sv
module init_ref_counter #(
    parameter int W     = 2,
    parameter int COUNT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    output logic group_done
);

    localparam logic [W-1:0] TARGET = W'(COUNT);

    logic [W-1:0] issued_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued_q <= '0;
        end else if (issue && issued_q != TARGET) begin
            issued_q <= issued_q + 1'b1;
        end
    end

    assign group_done = (issued_q == TARGET);

endmodule

// File: rtl/init_cmd_decode.sv
module init_cmd_decode
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10
) (
    input  init_cmd_t         cmd,
    input  logic [ADDR_W-1:0] mode_addr,
    output pin_cmd_t          pins,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        addr = '0;
        unique case (cmd)
            CMD_NOP: begin
                pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            end
            CMD_PRECHG: begin
                pins         = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
                addr[AP_BIT] = 1'b1;
            end
            CMD_REFRESH: begin
                pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            end
            CMD_MODESET: begin
                pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
                addr = mode_addr;
            end
        endcase
    end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int              CLK_MHZ       = 100,
    parameter int              REF_COUNT     = 2,
    parameter int              T_RP          = 3,
    parameter int              T_RFC         = 9,
    parameter int              T_MRD         = 2,
    parameter int              ADDR_W        = 12,
    parameter int              AP_BIT        = 10,
    parameter logic [ADDR_W-1:0] RSVD_MASK   = ADDR_W'(12'hC00),
    parameter logic [ADDR_W-1:0] MODE_WORD   = ADDR_W'(12'h032),
    parameter bit              USE_MODE_PORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_last,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              cke,
    output logic              dqm,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int STABLE_US  = 200;
    localparam int STABLE_CYC = clamp_min(CLK_MHZ * STABLE_US, 1);
    localparam int REF_N      = clamp_min(REF_COUNT, 2);
    localparam int RP_C       = clamp_min(T_RP, 1);
    localparam int RFC_C      = clamp_min(T_RFC, 1);
    localparam int MRD_C      = clamp_min(T_MRD, 1);
    localparam int MAX_C      = max2(max2(STABLE_CYC, RP_C), max2(RFC_C, MRD_C));
    localparam int TW         = $clog2(MAX_C + 1);
    localparam int RW         = $clog2(REF_N + 1);

    init_state_t       state_q, state_nx;
    init_cmd_t         cmd;
    pin_cmd_t          pins;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_expired;
    logic              refs_done;
    logic [ADDR_W-1:0] word_sel;
    logic [ADDR_W-1:0] mode_masked;

    // Mode word source and reserved-bit clearing
    assign word_sel    = USE_MODE_PORT ? mode_word : MODE_WORD;
    assign mode_masked = word_sel & ~RSVD_MASK;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STABLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_STABLE: begin
                if (tmr_expired) state_nx = ST_PRECHG;
            end
            ST_PRECHG: begin
                state_nx = ST_PRE_WAIT;
            end
            ST_PRE_WAIT: begin
                if (tmr_expired) state_nx = mode_last ? ST_REFRESH : ST_MODESET;
            end
            ST_REFRESH: begin
                state_nx = ST_REF_WAIT;
            end
            ST_REF_WAIT: begin
                if (tmr_expired) begin
                    if (!refs_done)     state_nx = ST_REFRESH;
                    else if (mode_last) state_nx = ST_MODESET;
                    else                state_nx = ST_READY;
                end
            end
            ST_MODESET: begin
                state_nx = ST_MODE_WAIT;
            end
            ST_MODE_WAIT: begin
                if (tmr_expired) state_nx = mode_last ? ST_READY : ST_REFRESH;
            end
            ST_READY: begin
                state_nx = ST_READY;
            end
        endcase
    end

    // Outputs and timer control, decoded from the current state
    always_comb begin
        cmd       = CMD_NOP;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        init_done = 1'b0;
        unique case (state_q)
            ST_STABLE, ST_PRE_WAIT, ST_REF_WAIT, ST_MODE_WAIT: begin
                cmd = CMD_NOP;
            end
            ST_PRECHG: begin
                cmd      = CMD_PRECHG;
                tmr_load = 1'b1;
                tmr_val  = TW'(RP_C - 1);
            end
            ST_REFRESH: begin
                cmd      = CMD_REFRESH;
                tmr_load = 1'b1;
                tmr_val  = TW'(RFC_C - 1);
            end
            ST_MODESET: begin
                cmd      = CMD_MODESET;
                tmr_load = 1'b1;
                tmr_val  = TW'(MRD_C - 1);
            end
            ST_READY: begin
                init_done = 1'b1;
            end
        endcase
    end

    init_wait_timer #(
        .W       (TW),
        .RST_VAL (TW'(STABLE_CYC - 1))
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    init_ref_counter #(
        .W     (RW),
        .COUNT (REF_N)
    ) u_refs (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (state_q == ST_REFRESH),
        .group_done (refs_done)
    );

    init_cmd_decode #(
        .ADDR_W (ADDR_W),
        .AP_BIT (AP_BIT)
    ) u_decode (
        .cmd       (cmd),
        .mode_addr (mode_masked),
        .pins      (pins),
        .addr      (addr)
    );

    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign cke   = 1'b1;
    assign dqm   = 1'b1;

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
    parameter int                STABLE_CYC = 200,
    parameter int                ADDR_W     = 12,
    parameter int                AP_BIT     = 10,
    parameter logic [ADDR_W-1:0] RSVD_MASK  = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              dqm,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);

    logic [31:0] since_q;
    logic        is_nop, is_pre, is_mrs;

    assign is_nop = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
    assign is_pre = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
    assign is_mrs = ({cs_n, ras_n, cas_n, we_n} == 4'b0000);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (since_q < 32'(STABLE_CYC)) begin
            since_q <= since_q + 1'b1;
        end
    end

    AST_CKE_DQM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cke && dqm); // R1
    AST_QUIET_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q < 32'(STABLE_CYC)) |-> is_nop); // R2
    AST_PRECHG_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> addr[AP_BIT]); // R3
    AST_MODE_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> ((addr & RSVD_MASK) == '0)); // R5
    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |=> is_nop); // R7
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> is_nop); // R8

endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
    .STABLE_CYC (STABLE_CYC),
    .ADDR_W     (ADDR_W),
    .AP_BIT     (AP_BIT),
    .RSVD_MASK  (RSVD_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .dqm       (dqm),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/sdram_pwrup_seq_test.sv
module sdram_pwrup_seq_test;

    localparam int CLK_MHZ   = 1;
    localparam int REF_COUNT = 1;
    localparam int T_RP      = 3;
    localparam int T_RFC     = 7;
    localparam int T_MRD     = 2;
    localparam int ADDR_W    = 12;
    localparam int STABLE    = CLK_MHZ * 200;
    localparam int NREF      = (REF_COUNT < 2) ? 2 : REF_COUNT;
    localparam logic [11:0] MASK = 12'hC00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_last = 1'b1;
    logic [11:0] mode_word = '0;
    logic        cke, dqm, cs_n, ras_n, cas_n, we_n, init_done;
    logic [11:0] addr;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sdram_pwrup_seq #(
        .CLK_MHZ       (CLK_MHZ),
        .REF_COUNT     (REF_COUNT),
        .T_RP          (T_RP),
        .T_RFC         (T_RFC),
        .T_MRD         (T_MRD),
        .ADDR_W        (ADDR_W),
        .USE_MODE_PORT (1'b1)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_last (mode_last),
        .mode_word (mode_word),
        .cke       (cke),
        .dqm       (dqm),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .init_done (init_done)
    );

    // Command codes: 0 NOP, 1 precharge-all, 2 refresh, 3 mode load, 4 NOP with done
    function automatic int item(input int i, input bit ml);
        if (i == 0) return 1;
        if (ml) return (i <= NREF) ? 2 : 3;
        return (i == 1) ? 3 : 2;
    endfunction

    function automatic int dly(input int c);
        if (c == 1) return T_RP;
        if (c == 2) return T_RFC;
        return T_MRD;
    endfunction

    function automatic int exp_at(input int k, input bit ml);
        int t = STABLE;
        for (int i = 0; i < NREF + 2; i++) begin
            if (k < t) return 0;
            if (k == t) return item(i, ml);
            t = t + 1 + dly(item(i, ml));
        end
        return (k >= t) ? 4 : 0;
    endfunction

    function automatic int done_time(input bit ml);
        int t = STABLE;
        for (int i = 0; i < NREF + 2; i++) t = t + 1 + dly(item(i, ml));
        return t;
    endfunction

    function automatic int exp_order(input bit ml);
        int o = 0;
        for (int i = 0; i < NREF + 2; i++) o = o * 4 + item(i, ml);
        return o;
    endfunction

    function automatic int pin_code();
        unique case ({cs_n, ras_n, cas_n, we_n})
            4'b0111: return 0;
            4'b0010: return 1;
            4'b0001: return 2;
            4'b0000: return 3;
            default: return 7;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start(input bit ml, input logic [11:0] w);
        rst_n = 1'b0;
        mode_last = ml;
        mode_word = w;
        #1;
        chk("R9 reset state", {pin_code(), init_done}, 0);
        chk("R1 reset state", {cke, dqm}, 3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Observe cycles 0..last after release; full run also checks order and done edge
    task automatic observe(input bit ml, input logic [11:0] w, input int last);
        int obs = 0;
        int done_k = -1;
        int e, code, ea;
        bit full = (last < 0);
        int stop = full ? done_time(ml) + 6 : last;
        string req;
        for (int k = 0; k <= stop; k++) begin
            if (k > 0) begin
                @(posedge clk);
                #1;
            end
            e = exp_at(k, ml);
            code = (e == 4) ? 0 : e;
            ea = (e == 1) ? 12'h400 : (e == 3) ? int'(w & ~MASK) : 0;
            if (e == 0) req = (k < STABLE) ? "R2" : "R7";
            else if (e == 1) req = "R3";
            else if (e == 2) req = "R4";
            else if (e == 3) req = "R5";
            else req = "R8";
            chk(req, (pin_code() << 16) | (int'(addr) << 1) | int'(init_done),
                (code << 16) | (ea << 1) | int'(e == 4));
            chk("R1", {cke, dqm}, 3);
            if (pin_code() != 0) obs = obs * 4 + pin_code();
            if (init_done && done_k < 0) done_k = k;
        end
        if (full) begin
            chk("R6 order", obs, exp_order(ml));
            chk("R8 done edge", done_k, done_time(ml));
        end
    endtask

    task automatic async_reset_check();
        #1;
        rst_n = 1'b0;
        #1;
        chk("R9 async", {pin_code(), init_done}, 0);
    endtask

    initial begin
        logic [11:0] w;
        bit ml;
        void'($urandom(32'h5EED_0001));
        // Directed: mode load last, all-ones word (reserved bits must clear)
        start(1'b1, 12'hFFF);
        observe(1'b1, 12'hFFF, -1);
        // Directed: mode load first, zero word
        start(1'b0, 12'h000);
        observe(1'b0, 12'h000, -1);
        // Reset inside the refresh group, then a full restart
        start(1'b1, 12'h032);
        observe(1'b1, 12'h032, STABLE + T_RP + 3);
        async_reset_check();
        start(1'b0, 12'h5A5);
        observe(1'b0, 12'h5A5, -1);
        // Reset after completion and during the quiet wait
        async_reset_check();
        start(1'b1, 12'h3C3);
        observe(1'b1, 12'h3C3, 50);
        async_reset_check();
        start(1'b1, 12'h3C3);
        observe(1'b1, 12'h3C3, -1);
        // Random straps and words
        for (int i = 0; i < 4; i++) begin
            ml = 1'($urandom % 2);
            w = 12'($urandom);
            start(ml, w);
            observe(ml, w, -1);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule